// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Flag

This block watches an analog comparator's digital output and raises a sticky interrupt flag when that output no longer agrees with a reference copy. The reference copy is refreshed only when software reads or writes the comparator control register. Until that register is accessed, a changed output counts as an open mismatch. While the mismatch is open, the flag is forced to 1 on every cycle, so software cannot clear it.

Before comparison, the raw comparator output is brought into the clock domain through a chain of flip-flops. The synchronized value appears at a fixed bit of the control register's read data. The usual interrupt service sequence is to touch the control register, which closes the mismatch, and then write 0 to the flag. Software may also write 1 to the flag to post an interrupt by hand. The interrupt request leaves the block only when three enables are all high: the local enable, the peripheral-group enable and the global enable.

Top module: `cci_change_irq`

## Requirements
- R1: The comparator input passes through two flip-flops before the comparison. A level change driven between edges therefore sets the flag at the third rising edge after the change, and not before.
- R2: On any cycle with no register access, if the synchronized output differs from the reference, the flag is 1 after the next edge. The flag stays 1 after the mismatch ends. This includes a comparator pulse only one cycle wide.
- R3: While a mismatch remains open, a software write of 0 to the flag does not take effect and the flag reads 1.
- R4: A read strobe or a write strobe on the control register copies the synchronized output into the reference at that edge, which ends the mismatch.
- R5: A flag write with data 1 sets the flag. A flag write with data 0 clears it, provided no mismatch is being counted in that cycle. Without a flag write or a mismatch, the flag holds its value.
- R6: In a cycle that has a control register access, a mismatch does not set the flag, even when the synchronized output changes in that same cycle. The reference update takes priority.
- R7: The interrupt output is 1 exactly when the flag is 1 and the local, peripheral and global enables are all 1. The enables have no effect on the flag itself.
- R8: Bit 6 of the control register read data equals the synchronized comparator output. The other seven bits read 0.
- R9: While reset (active-low, synchronous) is low, the flag is 0 and the reference follows the synchronized output. A comparator that is steady through reset therefore raises no flag after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_async_i | input | 1 | Raw comparator output, asynchronous to clk |
| ctl_rd_i | input | 1 | One-cycle read strobe of the comparator control register |
| ctl_wr_i | input | 1 | One-cycle write strobe of the comparator control register |
| ctl_rdata_o | output | 8 | Control register read data; bit 6 is the synchronized output |
| flag_wr_i | input | 1 | Software write strobe of the interrupt flag |
| flag_wdata_i | input | 1 | Value written to the flag |
| local_en_i | input | 1 | Comparator interrupt enable |
| periph_en_i | input | 1 | Peripheral-group interrupt enable |
| global_en_i | input | 1 | Global interrupt enable |
| flag_o | output | 1 | Sticky change-detect flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The assertions check on every cycle the relations that need no history beyond a few cycles. These are the synchronizer delay, flag setting on an unaccessed mismatch, refresh of the reference on an access, blocking of the flag set during an access, flag holding, and gating by each enable. Some behaviours show only across a sequence of accesses, so only the bench scenarios can show them. These are the full service order, where a clear fails before the register is touched and succeeds afterwards, the race in which the output changes in the very cycle of a read, a one-cycle comparator glitch that leaves a sticky flag, and a comparator held high through reset that raises nothing after release.

// File: rtl/cci_pkg.sv
package cci_pkg;

  // Width of the comparator control register read data.
  localparam int CTRL_W  = 8;
  // Position of the synchronized comparator output in that read data.
  localparam int OUT_POS = 6;

  // Next flag value. A counted mismatch dominates; otherwise a software
  // write loads its data; otherwise the flag holds.
  function automatic logic flag_next(input logic cur,
                                     input logic set_evt,
                                     input logic sw_wr,
                                     input logic sw_data);
    logic nxt;
    nxt = cur;
    if (sw_wr)   nxt = sw_data;
    if (set_evt) nxt = 1'b1;
    return nxt;
  endfunction

  // Interrupt request: flag qualified by every enable in the chain.
  function automatic logic irq_gate(input logic flag,
                                    input logic [2:0] en);
    return flag & (&en);
  endfunction

  // Read data with the comparator value placed at its bit and zeros elsewhere.
  function automatic logic [CTRL_W-1:0] ctl_pack(input logic cmp);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[OUT_POS] = cmp;
    return v;
  endfunction

endpackage

// File: rtl/cci_sync.sv
module cci_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  // Synchronizer flops carry no reset, so they keep sampling during reset.
  always_ff @(posedge clk) begin
    chain[0] <= d_async;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cci_ref_track.sv
module cci_ref_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_sync,
  input  logic access,
  output logic ref_q,
  output logic mismatch
);

  // The reference follows the synchronized output while in reset and on
  // every register access; otherwise it holds.
  always_ff @(posedge clk) begin
    if (!rst_n || access) ref_q <= cmp_sync;
  end

  assign mismatch = cmp_sync ^ ref_q;

endmodule

// File: rtl/cci_flag_reg.sv
module cci_flag_reg
  import cci_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic sw_wr,
  input  logic sw_data,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, set_evt, sw_wr, sw_data);
  end

endmodule

// File: rtl/cci_change_irq.sv
module cci_change_irq
  import cci_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_async_i,
  input  logic              ctl_rd_i,
  input  logic              ctl_wr_i,
  output logic [CTRL_W-1:0] ctl_rdata_o,
  input  logic              flag_wr_i,
  input  logic              flag_wdata_i,
  input  logic              local_en_i,
  input  logic              periph_en_i,
  input  logic              global_en_i,
  output logic              flag_o,
  output logic              irq_o
);

  localparam int EN_N = 3;

  // Named internal events, visible to the bound checker.
  logic            cmp_sync;
  logic            ref_q;
  logic            mismatch;
  logic            access;
  logic            set_evt;
  logic [EN_N-1:0] en_vec;

  cci_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (cmp_async_i),
    .q_sync  (cmp_sync)
  );

  assign access = ctl_rd_i | ctl_wr_i;

  cci_ref_track u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_sync (cmp_sync),
    .access   (access),
    .ref_q    (ref_q),
    .mismatch (mismatch)
  );

  // A register access takes priority over counting a mismatch.
  assign set_evt = mismatch & ~access;

  cci_flag_reg u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .sw_wr   (flag_wr_i),
    .sw_data (flag_wdata_i),
    .flag_q  (flag_o)
  );

  assign en_vec      = {global_en_i, periph_en_i, local_en_i};
  assign irq_o       = irq_gate(flag_o, en_vec);
  assign ctl_rdata_o = ctl_pack(cmp_sync);

endmodule

// File: rtl/cci_change_irq_chk.sv
module cci_change_irq_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_async_i,
  input logic       cmp_sync,
  input logic       ref_q,
  input logic       mismatch,
  input logic       access,
  input logic       flag_wr_i,
  input logic       flag_wdata_i,
  input logic       local_en_i,
  input logic       periph_en_i,
  input logic       global_en_i,
  input logic       flag_o,
  input logic       irq_o,
  input logic [7:0] ctl_rdata_o
);

  // The checker keeps its own history of the raw input and a warm-up count,
  // so the delay check waits until the history is filled.
  logic [SYNC_STAGES-1:0] hist;
  int                     warm = 0;

  always_ff @(posedge clk) begin
    hist[0] <= cmp_async_i;
    if (warm < SYNC_STAGES) warm <= warm + 1;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_hist
      always_ff @(posedge clk) hist[i] <= hist[i-1];
    end
  endgenerate

  // R1: synchronized value is the raw input delayed by the chain length
  a_r1_sync_delay: assert property (@(posedge clk)
    (warm >= SYNC_STAGES) |-> (cmp_sync == hist[SYNC_STAGES-1]));

  // R2: unaccessed mismatch sets the flag at the next edge
  a_r2_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !access) |=> flag_o);

  // R3: software clear loses against an open mismatch
  a_r3_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !access && flag_wr_i && !flag_wdata_i) |=> flag_o);

  // R4: an access loads the reference with the synchronized value
  a_r4_ref_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> (ref_q == $past(cmp_sync)));

  // R5: without a write or a counted mismatch the flag holds
  a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr_i && !(mismatch && !access)) |=> $stable(flag_o));

  // R5: a software write of 1 always sets the flag
  a_r5_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_i && flag_wdata_i) |=> flag_o);

  // R6: an access cycle never raises a cleared flag by itself
  a_r6_access_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !flag_wr_i && !flag_o) |=> !flag_o);

  // R7: request implies the flag and every enable
  a_r7_irq_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && local_en_i && periph_en_i && global_en_i));

  // R7: flag with every enable produces a request
  a_r7_irq_when_all: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && local_en_i && periph_en_i && global_en_i) |-> irq_o);

  // R8: status bit carries the synchronized value, other bits zero
  a_r8_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata_o[6] == cmp_sync) && ($countones(ctl_rdata_o) <= 1));

  // R9: flag is clear in the cycle after a reset cycle
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> !flag_o);

endmodule

bind cci_change_irq cci_change_irq_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_async_i  (cmp_async_i),
  .cmp_sync     (cmp_sync),
  .ref_q        (ref_q),
  .mismatch     (mismatch),
  .access       (access),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .local_en_i   (local_en_i),
  .periph_en_i  (periph_en_i),
  .global_en_i  (global_en_i),
  .flag_o       (flag_o),
  .irq_o        (irq_o),
  .ctl_rdata_o  (ctl_rdata_o)
);

// File: tb/tb_cci_change_irq.sv
module tb_cci_change_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] rdata;
  logic       fwr = 1'b0;
  logic       fwd = 1'b0;
  logic       en_l = 1'b0;
  logic       en_p = 1'b0;
  logic       en_g = 1'b0;
  logic       flag;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cci_change_irq dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_async_i  (cmp),
    .ctl_rd_i     (rd),
    .ctl_wr_i     (wr),
    .ctl_rdata_o  (rdata),
    .flag_wr_i    (fwr),
    .flag_wdata_i (fwd),
    .local_en_i   (en_l),
    .periph_en_i  (en_p),
    .global_en_i  (en_g),
    .flag_o       (flag),
    .irq_o        (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Vector: {cmp, acc[1:0] (1 read, 2 write), fop[1:0] (1 write 0, 2 write 1),
  //          en[2:0] = {local, periph, global}, exp_flag, exp_irq}
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_00_00_111_0_0,  // idle, no change
    10'b1_00_00_111_1_1,  // rise sets flag (R2)
    10'b1_00_01_111_1_1,  // clear blocked by open mismatch (R3)
    10'b1_01_01_111_0_0,  // read closes mismatch, clear works (R4)
    10'b1_00_00_111_0_0,  // no new mismatch
    10'b0_00_00_110_1_0,  // fall sets flag, global off (R7)
    10'b0_10_00_101_1_0,  // write access, periph off, flag held (R4, R7)
    10'b0_00_01_111_0_0,  // clear (R5)
    10'b0_00_10_111_1_1,  // software set (R5)
    10'b0_00_01_011_0_0,  // clear, local off
    10'b0_00_10_011_1_0,  // software set, local off (R7)
    10'b0_01_01_111_0_0   // read plus clear
  };

  task automatic run_vec(input logic [9:0] v);
    cmp = v[9];
    repeat (3) @(negedge clk);
    rd  = (v[8:7] == 2'd1);
    wr  = (v[8:7] == 2'd2);
    fwr = (v[6:5] != 2'd0);
    fwd = (v[6:5] == 2'd2);
    {en_l, en_p, en_g} = v[4:2];
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; fwr = 1'b0; fwd = 1'b0;
    check("R2/R3/R4/R5 flag", {7'd0, flag}, {7'd0, v[1]});
    check("R7 irq", {7'd0, irq}, {7'd0, v[0]});
    check("R8 status", rdata, {1'b0, v[9], 6'd0});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R9 flag in reset", {7'd0, flag}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 flag after reset", {7'd0, flag}, 8'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: flag appears at the third edge after the input change
    en_l = 1'b1; en_p = 1'b1; en_g = 1'b1;
    cmp = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 not yet set", {7'd0, flag}, 8'd0);
    @(negedge clk);
    check("R1 set on third edge", {7'd0, flag}, 8'd1);
    rd = 1'b1; fwr = 1'b1; fwd = 1'b0;
    @(negedge clk);
    rd = 1'b0; fwr = 1'b0;
    check("R4 cleared after access", {7'd0, flag}, 8'd0);

    // R6: synchronized value changes in the very cycle of a read
    cmp = 1'b0;
    @(negedge clk); @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R6 no set on access cycle", {7'd0, flag}, 8'd0);
    repeat (2) @(negedge clk);
    check("R6 mismatch closed", {7'd0, flag}, 8'd0);

    // R2: one-cycle glitch leaves a sticky flag
    cmp = 1'b1;
    @(negedge clk);
    cmp = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 glitch sticky flag", {7'd0, flag}, 8'd1);
    check("R7 glitch irq", {7'd0, irq}, 8'd1);
    fwr = 1'b1; fwd = 1'b0;
    @(negedge clk);
    fwr = 1'b0;
    check("R5 clear after glitch", {7'd0, flag}, 8'd0);

    // R9: input high through reset raises nothing after release
    cmp = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 no flag after release", {7'd0, flag}, 8'd0);
    check("R9 irq after release", {7'd0, irq}, 8'd0);
    check("R8 status after reset", rdata, 8'h40);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule